// File: doc/BRIEF.md
# Predictive Memory Bank Wake-Up Power Manager

This block keeps a power state for each bank of a banked on-chip memory: asleep, waking or active. It sits beside the bus arbiter and watches the grant. When a grant arrives, the upper address bits of the granted transfer name the bank the transfer will use. The block starts the wake-up of that bank at once, so the wake latency overlaps the address phase and does not wait for the first data access.

Each bank has a power-enable output that drives its power switch and a ready flag that the memory path uses. A bank is ready only after it has finished its fixed wake-up interval. An access to a bank that is not ready gets a combinational stall. An active bank that sees no traffic for a programmable number of cycles drops back to sleep. Reset puts every bank to sleep.

Top module: `bank_wake_mgr`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every bit of `bank_pwr_en` and `bank_ready` is 0.
- R2: The target bank is the top log2(NUM_BANKS) bits of the address (bits 19:16 by default). A grant sampled at a clock edge raises that bank's `bank_pwr_en` bit in the next cycle.
- R3: After `bank_pwr_en` of a bank rises, the bank's `bank_ready` stays low for exactly WAKE_CYCLES cycles (50 by default) and is then 1.
- R4: A grant or an access changes only the bank it targets. An access on its own never powers a sleeping bank.
- R5: `acc_stall` is 1 in the same cycle exactly when `acc_valid` is 1 and the bank addressed by `acc_addr` is not ready.
- R6: An active bank goes to sleep (power-enable and ready both 0) after `idle_limit` consecutive cycles in which neither a grant nor an access targets it. A grant or an access to that bank restarts the count. Traffic to other banks does not.
- R7: A grant to a bank that is already waking or active does not restart its wake-up interval and does not clear its ready flag.
- R8: When `idle_limit` is 0, active banks never go back to sleep.
- R9: A bank's ready flag is never 1 while its power-enable is 0, and a bank only goes to sleep from the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_valid | input | 1 | Arbiter has granted a transfer this cycle |
| grant_addr | input | ADDR_W | Start address of the granted transfer |
| acc_valid | input | 1 | Memory access request this cycle |
| acc_addr | input | ADDR_W | Address of the memory access |
| idle_limit | input | IDLE_W | Idle cycles before an active bank sleeps; 0 disables sleeping |
| bank_pwr_en | output | NUM_BANKS | Per-bank power switch enable |
| bank_ready | output | NUM_BANKS | Per-bank ready (active) flag |
| acc_stall | output | 1 | Current access targets a bank that is not ready |

## Verification
The hardest case to reach from the ports is the one where a bank's idle count is restarted while the bank is already active. The bench must show that the sleep point moves by the right amount, and that a grant to a powered bank does not also restart its wake-up interval. To get there, the stimulus wakes a bank, lets its idle count run part way, then gives it one access, one access to an unrelated bank and one further grant, each at a chosen cycle. The scoreboard holds expectations at the exact cycles where the bank would sleep under each wrong interpretation, as well as at the correct cycle.

// File: rtl/bank_pwr_pkg.sv
package bank_pwr_pkg;

    typedef enum logic [1:0] {
        PS_SLEEP  = 2'd0,
        PS_WAKE   = 2'd1,
        PS_ACTIVE = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic wake_req;   // grant targets this bank
        logic touch;      // grant or access targets this bank
    } bank_evt_t;

    typedef struct packed {
        logic pwr_en;
        logic ready;
    } bank_stat_t;

    function automatic logic state_powered(input pwr_state_e s);
        return (s != PS_SLEEP);
    endfunction

    function automatic logic state_ready(input pwr_state_e s);
        return (s == PS_ACTIVE);
    endfunction

endpackage

// File: rtl/bank_addr_decode.sv
module bank_addr_decode #(
    parameter int ADDR_W    = 20,
    parameter int NUM_BANKS = 16
) (
    input  logic                 valid,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] sel
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LOW_W  = ADDR_W - BANK_W;

    logic [BANK_W-1:0] idx;
    logic              unused_low;

    assign idx        = addr[ADDR_W-1 -: BANK_W];
    assign unused_low = ^addr[LOW_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign sel[b] = valid && (idx == BANK_W'(b));
    end

endmodule

// File: rtl/bank_pwr_fsm.sv
module bank_pwr_fsm
    import bank_pwr_pkg::*;
#(
    parameter int WAKE_CYCLES = 50,
    parameter int IDLE_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_evt_t         evt,
    input  logic [IDLE_W-1:0] idle_limit,
    output bank_stat_t        stat
);
    localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_CYCLES - 1);

    pwr_state_e        state_q;
    logic [WAKE_W-1:0] wake_cnt_q;
    logic [IDLE_W-1:0] idle_cnt_q;
    logic              sleep_on;
    logic              idle_done;

    assign sleep_on  = (idle_limit != '0);
    assign idle_done = sleep_on && (idle_cnt_q == idle_limit - IDLE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PS_SLEEP;
            wake_cnt_q <= '0;
            idle_cnt_q <= '0;
        end else begin
            case (state_q)
                PS_SLEEP: begin
                    if (evt.wake_req) begin
                        state_q    <= PS_WAKE;
                        wake_cnt_q <= WAKE_LOAD;
                    end
                end
                PS_WAKE: begin
                    if (wake_cnt_q == '0) begin
                        state_q    <= PS_ACTIVE;
                        idle_cnt_q <= '0;
                    end else begin
                        wake_cnt_q <= wake_cnt_q - WAKE_W'(1);
                    end
                end
                PS_ACTIVE: begin
                    if (evt.touch) begin
                        idle_cnt_q <= '0;
                    end else if (idle_done) begin
                        state_q    <= PS_SLEEP;
                        idle_cnt_q <= '0;
                    end else if (sleep_on) begin
                        idle_cnt_q <= idle_cnt_q + IDLE_W'(1);
                    end
                end
                default: state_q <= PS_SLEEP;
            endcase
        end
    end

    assign stat.pwr_en = state_powered(state_q);
    assign stat.ready  = state_ready(state_q);

endmodule

// File: rtl/bank_wake_mgr.sv
module bank_wake_mgr
    import bank_pwr_pkg::*;
#(
    parameter int NUM_BANKS   = 16,
    parameter int ADDR_W      = 20,
    parameter int WAKE_CYCLES = 50,
    parameter int IDLE_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 grant_valid,
    input  logic [ADDR_W-1:0]    grant_addr,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [IDLE_W-1:0]    idle_limit,
    output logic [NUM_BANKS-1:0] bank_pwr_en,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic                 acc_stall
);
    logic [NUM_BANKS-1:0] grant_sel;
    logic [NUM_BANKS-1:0] acc_sel;

    bank_addr_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_grant_dec (
        .valid (grant_valid),
        .addr  (grant_addr),
        .sel   (grant_sel)
    );

    bank_addr_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_acc_dec (
        .valid (acc_valid),
        .addr  (acc_addr),
        .sel   (acc_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_evt_t  evt;
        bank_stat_t stat;

        assign evt.wake_req = grant_sel[b];
        assign evt.touch    = grant_sel[b] | acc_sel[b];

        bank_pwr_fsm #(.WAKE_CYCLES(WAKE_CYCLES), .IDLE_W(IDLE_W)) u_fsm (
            .clk        (clk),
            .rst        (rst),
            .evt        (evt),
            .idle_limit (idle_limit),
            .stat       (stat)
        );

        assign bank_pwr_en[b] = stat.pwr_en;
        assign bank_ready[b]  = stat.ready;
    end

    // acc_sel is zero when acc_valid is low
    assign acc_stall = |(acc_sel & ~bank_ready);

endmodule

// File: rtl/bank_wake_chk.sv
module bank_wake_chk #(
    parameter int NUM_BANKS   = 16,
    parameter int ADDR_W      = 20,
    parameter int WAKE_CYCLES = 50,
    parameter int IDLE_W      = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 grant_valid,
    input logic [ADDR_W-1:0]    grant_addr,
    input logic                 acc_valid,
    input logic [ADDR_W-1:0]    acc_addr,
    input logic [IDLE_W-1:0]    idle_limit,
    input logic [NUM_BANKS-1:0] bank_pwr_en,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic                 acc_stall
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2(WAKE_CYCLES + 2);

    logic [BANK_W-1:0] g_idx;
    logic [BANK_W-1:0] a_idx;
    assign g_idx = grant_addr[ADDR_W-1 -: BANK_W];
    assign a_idx = acc_addr[ADDR_W-1 -: BANK_W];

    // R5
    stall_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
        acc_stall |-> acc_valid);

    // R5
    unstalled_bank_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_stall) |-> bank_ready[a_idx]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        logic [CNT_W-1:0] wake_seen;

        always_ff @(posedge clk) begin
            if (rst || !bank_pwr_en[b] || bank_ready[b])
                wake_seen <= '0;
            else if (wake_seen != CNT_W'(WAKE_CYCLES + 1))
                wake_seen <= wake_seen + CNT_W'(1);
        end

        // R9
        ready_needs_pwr_chk: assert property (@(posedge clk) disable iff (rst)
            bank_ready[b] |-> bank_pwr_en[b]);

        // R3 / R7
        wake_length_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_ready[b]) |-> (wake_seen == CNT_W'(WAKE_CYCLES)));

        // R2 / R4
        wake_only_on_grant_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_pwr_en[b]) |-> $past(grant_valid && (g_idx == BANK_W'(b))));

        // R9
        sleep_from_active_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(bank_pwr_en[b]) |-> $past(bank_ready[b]));

        // R8
        no_sleep_when_off_chk: assert property (@(posedge clk) disable iff (rst)
            ((idle_limit == '0) && $past(idle_limit == '0)) |-> !$fell(bank_ready[b]));
    end

endmodule

bind bank_wake_mgr bank_wake_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .ADDR_W      (ADDR_W),
    .WAKE_CYCLES (WAKE_CYCLES),
    .IDLE_W      (IDLE_W)
) u_bank_wake_chk (
    .clk         (clk),
    .rst         (rst),
    .grant_valid (grant_valid),
    .grant_addr  (grant_addr),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .idle_limit  (idle_limit),
    .bank_pwr_en (bank_pwr_en),
    .bank_ready  (bank_ready),
    .acc_stall   (acc_stall)
);

// File: tb/tb_bank_wake_mgr.sv
`timescale 1ns/1ps
module tb_bank_wake_mgr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        grant_valid = 1'b0;
    logic [19:0] grant_addr = '0;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_addr = '0;
    logic [15:0] idle_limit = '0;
    logic [15:0] bank_pwr_en;
    logic [15:0] bank_ready;
    logic        acc_stall;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bank_wake_mgr dut (
        .clk(clk), .rst(rst),
        .grant_valid(grant_valid), .grant_addr(grant_addr),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .idle_limit(idle_limit),
        .bank_pwr_en(bank_pwr_en), .bank_ready(bank_ready),
        .acc_stall(acc_stall)
    );

    typedef struct {
        int          at;
        bit          is_stall;
        logic [15:0] pwr;
        logic [15:0] rdy;
        logic        stall;
        string       req;
    } exp_t;

    exp_t q[$];

    function automatic void push(exp_t e);
        int k = q.size();
        while (k > 0 && q[k-1].at > e.at) k--;
        q.insert(k, e);
    endfunction

    function automatic void exp_state(int at, logic [15:0] p, logic [15:0] r, string req);
        exp_t e;
        e.at = at; e.is_stall = 1'b0; e.pwr = p; e.rdy = r; e.stall = 1'b0; e.req = req;
        push(e);
    endfunction

    function automatic void exp_stall(int at, logic s, string req);
        exp_t e;
        e.at = at; e.is_stall = 1'b1; e.pwr = '0; e.rdy = '0; e.stall = s; e.req = req;
        push(e);
    endfunction

    // monitor: compare expectations due this cycle
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].at <= cyc) begin
            e = q.pop_front();
            checks++;
            if (e.at < cyc) begin
                failures++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.req, e.at, cyc);
            end else if (e.is_stall) begin
                if (acc_stall !== e.stall) begin
                    failures++;
                    $display("FAIL %s: cycle %0d acc_stall=%b expected %b", e.req, cyc, acc_stall, e.stall);
                end
            end else if (bank_pwr_en !== e.pwr || bank_ready !== e.rdy) begin
                failures++;
                $display("FAIL %s: cycle %0d pwr=%h rdy=%h expected pwr=%h rdy=%h",
                         e.req, cyc, bank_pwr_en, bank_ready, e.pwr, e.rdy);
            end
        end
    end

    function automatic logic [19:0] addr_of(int bank, logic [15:0] low);
        return {bank[3:0], low};
    endfunction

    task automatic at_cycle(int t);
        while (cyc < t - 1) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset(logic [15:0] lim);
        rst = 1'b1; grant_valid = 1'b0; acc_valid = 1'b0; idle_limit = lim;
        repeat (3) @(posedge clk);
        #1;
        exp_state(cyc, '0, '0, "R1 in reset");
        @(posedge clk); #1;
        rst = 1'b0;
        exp_state(cyc, '0, '0, "R1 after reset");
    endtask

    task automatic grant_at(int t, int bank, logic [15:0] low);
        at_cycle(t);
        @(posedge clk); #1;
        grant_valid = 1'b1; grant_addr = addr_of(bank, low);
        @(posedge clk); #1;
        grant_valid = 1'b0;
    endtask

    task automatic access_at(int t, int bank, logic s, string req);
        at_cycle(t);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_addr = addr_of(bank, 16'h00A4);
        exp_stall(cyc, s, req);
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    localparam logic [15:0] B0  = 16'h0001;
    localparam logic [15:0] B3  = 16'h0008;
    localparam logic [15:0] B9  = 16'h0200;
    localparam logic [15:0] B15 = 16'h8000;

    initial begin
        int c;
        int a;

        // S1/S2: wake timing, single-bank targeting, stalls, no restart
        do_reset(16'd0);
        c = cyc + 2;
        exp_state(c + 1,  B3, '0, "R2 pwr_en rises next cycle");
        exp_state(c + 50, B3, '0, "R3 still waking at cycle 50");
        exp_state(c + 51, B3, B3, "R3/R7 ready after 50 cycles despite regrant");
        exp_state(c + 5,  B3, '0, "R4 access does not wake bank 5");
        exp_state(c + 80, B3, B3, "R4 only bank 3 powered");
        grant_at(c, 3, 16'h4567);
        access_at(c + 2, 3, 1'b1, "R5 stall while waking");
        access_at(c + 4, 5, 1'b1, "R5 stall on sleeping bank");
        grant_at(c + 20, 3, 16'hFFF0);
        access_at(c + 55, 3, 1'b0, "R5 no stall on ready bank");
        access_at(c + 58, 5, 1'b1, "R5 stall on other bank");
        drain();

        // S3: idle sleep and touch restart
        do_reset(16'd8);
        c = cyc + 2;
        exp_state(c + 51, B9, B9, "R3 bank 9 ready");
        exp_state(c + 58, B9, B9, "R6 active for idle_limit cycles");
        exp_state(c + 59, '0, '0, "R6 sleep after idle_limit");
        grant_at(c, 9, 16'h1234);
        drain();

        c = cyc + 2;
        a = c + 55;
        exp_state(c + 51, B9, B9, "R3 bank 9 ready again");
        exp_state(a + 4,  B9, B9, "R6 access restarted idle count");
        exp_state(a + 6,  B9, B9, "R7 grant on active bank keeps ready");
        exp_state(a + 9,  B9, B9, "R6 grant restarted idle count");
        exp_state(a + 13, B9, B9, "R6 active until count expires");
        exp_state(a + 14, '0, '0, "R6 sleep after restarted count");
        grant_at(c, 9, 16'h0000);
        access_at(a, 9, 1'b0, "R5 no stall on active bank 9");
        access_at(a + 2, 2, 1'b1, "R6 access to other bank is stalled");
        grant_at(a + 5, 9, 16'h8888);
        drain();

        // S4: two banks, idle sleep disabled
        do_reset(16'd0);
        c = cyc + 2;
        exp_state(c + 1,   B0,       '0,       "R2 bank 0 from address 0x00000");
        exp_state(c + 3,   B0 | B15, '0,       "R2/R4 bank 15 from address 0xFFFFF");
        exp_state(c + 51,  B0 | B15, B0,       "R3 bank 0 ready");
        exp_state(c + 53,  B0 | B15, B0 | B15, "R3 bank 15 ready");
        exp_state(c + 400, B0 | B15, B0 | B15, "R8 no sleep with idle_limit 0");
        grant_at(c, 0, 16'h0000);
        grant_at(c + 2, 15, 16'hFFFF);
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: cycle %0d expected completion before 20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule